// File: doc/BRIEF.md
# Whitened Packet Framer with Periodic Sync

This block turns fixed-length packets into a stream of symbol requests for a downstream 8b/10b encoder. Each request is an 8-bit value plus a flag that marks it as a control character. Payload bytes are whitened with a xorshift32 keystream, and a CRC32 trailer is appended. Every packet is closed by an end marker. The marker is one of two control characters, and the rarer one also reseeds the whitening generator. On a fixed cadence, an idle control character replaces whatever would have been sent next.

A producer fills packet payloads through a byte write port and hands each packet over with a commit strobe, at any time. Three payload banks rotate between the producer, a pending slot and the reader. A committed packet therefore only enters the stream at a packet boundary, and the packet being sent is never disturbed. The consumer takes symbols over a valid/ready handshake. All framing state advances only when a symbol is accepted.

Top module: `sym_framer`

## Requirements
- R1: Every third accepted symbol after reset is the idle character K23.7 (value 0xF7, K flag 1). An idle slot leaves the packet byte position, the keystream and the CRC unchanged.
- R2: After the PKT_BYTES symbols of a packet (payload followed by the 4 CRC bytes), the next non-idle symbol is an end marker with the K flag set. It is normally K27.7 (value 0xFB).
- R3: The end marker is K28.1 (value 0x3C) when the sync countdown is zero, and the countdown then reloads to SYNC_RELOAD (13). Every K27.7 decrements it, so K28.1 closes one packet in every SYNC_RELOAD+1.
- R4: The sync countdown is zero after reset, so the first end marker after reset is K28.1.
- R5: Accepting K28.1 sets the whitening state to the xorshift32 successor of SEED (1).
- R6: For each payload or CRC byte, the whitening state first advances one xorshift32 step (x^=x<<13, x^=x>>17, x^=x<<5, 32 bits). The byte is then XORed with bits 7:0 of the new state, and the K flag is 0. After reset the state is the successor of SEED.
- R7: The 4 symbols after the payload carry CRC32 over the payload bytes in order, least significant byte first, whitened as in R6. The CRC uses the reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and final inversion.
- R8: Payload byte i is written with wr_addr = i and is sent as the i-th symbol of its packet. A commit swaps the write bank with the pending bank and flags it. When an end marker is accepted with the flag set, the pending and read banks swap, so the next packet carries the latest committed payload. A packet already being sent is never altered.
- R9: While sym_valid is high and sym_ready is low, sym_data and sym_k hold steady. No framing state advances without an accepted handshake.
- R10: sym_valid is low during reset and high from the first cycle after reset release. The read bank resets to zeros, so the first packet has an all-zero payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one payload byte into the write bank |
| wr_addr | input | AW | Payload byte index (0 is sent first) |
| wr_data | input | 8 | Payload byte value |
| commit | input | 1 | Hand the write bank over as the pending packet |
| sym_valid | output | 1 | Symbol request present |
| sym_ready | input | 1 | Consumer accepts the symbol this cycle |
| sym_data | output | 8 | Byte value or control character code |
| sym_k | output | 1 | 1 marks a control character |

## Verification
The bench builds the block with PKT_BYTES = 8 (4 payload bytes) and the default SYNC_RELOAD of 13. A packet then spans only about 13 symbols including idles. A few thousand cycles therefore cover many full sync periods, many bank swaps and every phase alignment between the idle cadence and packet boundaries. This includes idles landing on marker slots and CRC slots. With the small payload, random commits fall at every byte position of a packet in flight and often coincide with a marker slot. Random back-pressure exercises stalls in each symbol kind.

// File: rtl/pf_pkg.sv
package pf_pkg;

  typedef enum logic [1:0] {
    SK_DATA = 2'd0,
    SK_CRC  = 2'd1,
    SK_MARK = 2'd2,
    SK_IDLE = 2'd3
  } slot_kind_e;

  localparam logic [7:0] K_IDLE_CODE = 8'hF7;
  localparam logic [7:0] K_MARK_CODE = 8'hFB;
  localparam logic [7:0] K_SYNC_CODE = 8'h3C;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;

  function automatic logic [31:0] xs32_step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/pf_tribuf.sv
module pf_tribuf #(
  parameter int PAY = 12,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  input  logic          swap_req,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  localparam int NBANK = 3;

  logic [1:0] wr_idx_q, idle_idx_q, rd_idx_q;
  logic [1:0] wr_idx_n, idle_idx_n, rd_idx_n, tmp_idx;
  logic       pend_q, pend_n;
  logic [NBANK-1:0][7:0] bank_rd;

  // bank rotation: commit first, then packet-boundary swap
  always_comb begin
    wr_idx_n   = wr_idx_q;
    idle_idx_n = idle_idx_q;
    rd_idx_n   = rd_idx_q;
    pend_n     = pend_q;
    tmp_idx    = 2'd0;
    if (commit) begin
      wr_idx_n   = idle_idx_q;
      idle_idx_n = wr_idx_q;
      pend_n     = 1'b1;
    end
    if (swap_req && pend_n) begin
      tmp_idx    = idle_idx_n;
      idle_idx_n = rd_idx_n;
      rd_idx_n   = tmp_idx;
      pend_n     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q   <= 2'd2;
      idle_idx_q <= 2'd1;
      rd_idx_q   <= 2'd0;
      pend_q     <= 1'b0;
    end else begin
      wr_idx_q   <= wr_idx_n;
      idle_idx_q <= idle_idx_n;
      rd_idx_q   <= rd_idx_n;
      pend_q     <= pend_n;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [7:0] mem_q [PAY];
    logic       wen;
    assign wen = wr_en && (wr_idx_q == 2'(b)) && (int'(wr_addr) < PAY);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < PAY; i++) mem_q[i] <= 8'h00;
      end else if (wen) begin
        mem_q[wr_addr] <= wr_data;
      end
    end

    assign bank_rd[b] = mem_q[rd_addr];
  end

  assign rd_data = bank_rd[rd_idx_q];

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_req |=> $stable(rd_idx_q));
  // R8
  commit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !swap_req) |=> pend_q);
  // R8
  wr_rd_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx_q != rd_idx_q) && (idle_idx_q != rd_idx_q));

endmodule

// File: rtl/pf_sequencer.sv
module pf_sequencer
  import pf_pkg::*;
#(
  parameter int PKT_BYTES   = 16,
  parameter int IDLE_EVERY  = 3,
  parameter int SYNC_RELOAD = 13,
  parameter int PW          = $clog2(PKT_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output slot_kind_e    kind,
  output logic [PW-1:0] pos,
  output logic          sync_zero
);

  localparam int PAY = PKT_BYTES - 4;
  localparam int CW  = $clog2(IDLE_EVERY);
  localparam int SW  = $clog2(SYNC_RELOAD + 1);

  logic [CW-1:0] slot_q, slot_n;
  logic [PW-1:0] pos_q, pos_n;
  logic [SW-1:0] sync_q, sync_n;

  always_comb begin
    if (slot_q == CW'(IDLE_EVERY - 1))   kind = SK_IDLE;
    else if (pos_q == PW'(PKT_BYTES))    kind = SK_MARK;
    else if (pos_q >= PW'(PAY))          kind = SK_CRC;
    else                                 kind = SK_DATA;
  end

  always_comb begin
    slot_n = slot_q;
    pos_n  = pos_q;
    sync_n = sync_q;
    if (adv) begin
      if (kind == SK_IDLE) begin
        slot_n = '0;
      end else begin
        slot_n = slot_q + 1'b1;
        if (kind == SK_MARK) begin
          pos_n  = '0;
          sync_n = (sync_q == '0) ? SW'(SYNC_RELOAD) : sync_q - 1'b1;
        end else begin
          pos_n = pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      pos_q  <= '0;
      sync_q <= '0;
    end else begin
      slot_q <= slot_n;
      pos_q  <= pos_n;
      sync_q <= sync_n;
    end
  end

  assign pos       = pos_q;
  assign sync_zero = (sync_q == '0);

  // R1
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && kind == SK_IDLE) |=> (kind != SK_IDLE));
  // R1
  idle_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && kind == SK_IDLE) |=> $stable(pos_q) && $stable(sync_q));
  // R3
  sync_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q <= SW'(SYNC_RELOAD));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pos_q) && $stable(slot_q));

endmodule

// File: rtl/pf_whitener.sv
module pf_whitener
  import pf_pkg::*;
#(
  parameter logic [31:0] SEED = 32'h1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  slot_kind_e kind,
  input  logic       sync_zero,
  input  logic [7:0] raw,
  input  logic [1:0] crc_sel,
  output logic [7:0] sym_data,
  output logic       sym_k
);

  localparam logic [31:0] RESEED = xs32_step(SEED);

  logic [31:0] scr_q, scr_n, scr_adv;
  logic [31:0] crc_q, crc_n, crc_fin;
  logic [7:0]  crc_b;

  assign scr_adv = xs32_step(scr_q);
  assign crc_fin = ~crc_q;
  assign crc_b   = crc_fin[8*crc_sel +: 8];

  always_comb begin
    case (kind)
      SK_IDLE: begin sym_data = K_IDLE_CODE; sym_k = 1'b1; end
      SK_MARK: begin sym_data = sync_zero ? K_SYNC_CODE : K_MARK_CODE; sym_k = 1'b1; end
      SK_CRC:  begin sym_data = crc_b ^ scr_adv[7:0]; sym_k = 1'b0; end
      default: begin sym_data = raw ^ scr_adv[7:0]; sym_k = 1'b0; end
    endcase
  end

  always_comb begin
    scr_n = scr_q;
    crc_n = crc_q;
    if (adv) begin
      case (kind)
        SK_DATA: begin scr_n = scr_adv; crc_n = crc32_byte(crc_q, raw); end
        SK_CRC:  scr_n = scr_adv;
        SK_MARK: begin
          crc_n = 32'hFFFF_FFFF;
          if (sync_zero) scr_n = RESEED;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scr_q <= RESEED;
      crc_q <= 32'hFFFF_FFFF;
    end else begin
      scr_q <= scr_n;
      crc_q <= crc_n;
    end
  end

  // R5
  reseed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && kind == SK_MARK && sync_zero) |=> (scr_q == RESEED));
  // R6
  scr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (kind == SK_DATA || kind == SK_CRC)) |=> (scr_q != $past(scr_q)));
  // R6
  scr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scr_q != 32'h0);
  // R1
  idle_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && kind == SK_IDLE) |=> $stable(scr_q) && $stable(crc_q));

endmodule

// File: rtl/sym_framer.sv
module sym_framer
  import pf_pkg::*;
#(
  parameter int          PKT_BYTES   = 16,
  parameter int          IDLE_EVERY  = 3,
  parameter int          SYNC_RELOAD = 13,
  parameter logic [31:0] SEED        = 32'h1,
  parameter int          AW          = $clog2(PKT_BYTES - 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  output logic          sym_valid,
  input  logic          sym_ready,
  output logic [7:0]    sym_data,
  output logic          sym_k
);

  localparam int PAY = PKT_BYTES - 4;
  localparam int PW  = $clog2(PKT_BYTES + 1);

  logic          valid_q;
  logic          accept;
  logic          swap_req;
  slot_kind_e    kind;
  logic [PW-1:0] pos;
  logic [PW-1:0] crc_off;
  logic          sync_zero;
  logic [7:0]    raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end

  assign sym_valid = valid_q;
  assign accept    = valid_q && sym_ready;
  assign swap_req  = accept && (kind == SK_MARK);
  assign crc_off   = pos - PW'(PAY);

  pf_sequencer #(
    .PKT_BYTES  (PKT_BYTES),
    .IDLE_EVERY (IDLE_EVERY),
    .SYNC_RELOAD(SYNC_RELOAD),
    .PW         (PW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (accept),
    .kind     (kind),
    .pos      (pos),
    .sync_zero(sync_zero)
  );

  pf_tribuf #(
    .PAY(PAY),
    .AW (AW)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .commit  (commit),
    .swap_req(swap_req),
    .rd_addr (pos[AW-1:0]),
    .rd_data (raw)
  );

  pf_whitener #(
    .SEED(SEED)
  ) u_wht (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (accept),
    .kind     (kind),
    .sync_zero(sync_zero),
    .raw      (raw),
    .crc_sel  (crc_off[1:0]),
    .sym_data (sym_data),
    .sym_k    (sym_k)
  );

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_ready) |=> $stable(sym_data) && $stable(sym_k));
  // R10
  valid_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> sym_valid);

endmodule

// File: tb/tb_sym_framer.sv
module tb_sym_framer;

  localparam int PKT = 8;
  localparam int PAY = PKT - 4;
  localparam int AW  = 2;
  localparam int RELOAD = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = 8'h00;
  logic commit = 1'b0;
  logic sym_ready = 1'b0;
  logic sym_valid;
  logic [7:0] sym_data;
  logic sym_k;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sym_framer #(.PKT_BYTES(PKT), .SYNC_RELOAD(RELOAD), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_data(sym_data), .sym_k(sym_k));

  // reference functions written from the requirements
  function automatic bit [31:0] ref_xs(input bit [31:0] x);
    bit [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic bit [31:0] ref_crc(input bit [31:0] c, input bit [7:0] b);
    bit [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // model state
  int m_slot, m_pos, m_sync;
  bit [31:0] m_scr, m_crc;
  bit [7:0] rd_m [PAY];
  bit [7:0] idle_m [PAY];
  bit [7:0] wr_m [PAY];
  bit m_pend;
  int n_marks = 0, n_sync_marks = 0;
  bit first_mark_seen = 1'b0;

  task automatic model_symbol(output bit [7:0] d, output bit k, output string tag);
    bit [7:0] b;
    bit [31:0] c;
    if (m_slot == 2) begin
      d = 8'hF7; k = 1'b1; tag = "R1"; m_slot = 0;
    end else begin
      m_slot++;
      if (m_pos == PKT) begin
        k = 1'b1;
        if (m_sync == 0) begin
          d = 8'h3C; m_sync = RELOAD; m_scr = ref_xs(32'h1); tag = "R3 R4 R5";
        end else begin
          d = 8'hFB; m_sync--; tag = "R2";
        end
        m_pos = 0;
        m_crc = 32'hFFFF_FFFF;
        if (m_pend) begin
          for (int i = 0; i < PAY; i++) rd_m[i] = idle_m[i];
          m_pend = 1'b0;
        end
      end else if (m_pos < PAY) begin
        b = rd_m[m_pos];
        m_scr = ref_xs(m_scr);
        d = b ^ m_scr[7:0]; k = 1'b0; tag = "R6 R8 R10";
        m_crc = ref_crc(m_crc, b);
        m_pos++;
      end else begin
        c = ~m_crc;
        m_scr = ref_xs(m_scr);
        d = 8'(c >> (8 * (m_pos - PAY))) ^ m_scr[7:0]; k = 1'b0; tag = "R7";
        m_pos++;
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    bit [7:0] ed;
    bit ek;
    string tag;
    int prod_cnt;
    bit r, cm;
    bit prev_stall;
    bit [7:0] prev_d;
    bit prev_k;

    void'($urandom(32'd20240611));
    m_slot = 0; m_pos = 0; m_sync = 0;
    m_scr = ref_xs(32'h1); m_crc = 32'hFFFF_FFFF; m_pend = 1'b0;
    for (int i = 0; i < PAY; i++) begin rd_m[i] = 8'h00; idle_m[i] = 8'h00; wr_m[i] = 8'h00; end
    prod_cnt = 0;
    prev_stall = 1'b0; prev_d = 8'h00; prev_k = 1'b0;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(sym_valid == 1'b0, "R10 valid in reset", int'(sym_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sym_valid == 1'b1, "R10 valid after reset", int'(sym_valid), 1);

    for (int cyc = 0; cyc < 6000; cyc++) begin
      // R9: a stalled symbol must not change
      if (prev_stall) begin
        check(sym_data == prev_d && sym_k == prev_k, "R9 hold under stall",
              int'({sym_k, sym_data}), int'({prev_k, prev_d}));
      end

      // consumer ready: directed full-rate phase, random phase, sparse phase
      if (cyc < 400)        r = 1'b1;
      else if (cyc < 4000)  r = ($urandom % 4) != 0;
      else                  r = ($urandom % 3) == 0;

      // producer: fill payload, then commit (never both in one cycle)
      wr_en = 1'b0; commit = 1'b0; cm = 1'b0;
      if (prod_cnt < PAY) begin
        if (cyc < 400 || ($urandom % 2) == 0) begin
          wr_en = 1'b1;
          wr_addr = AW'(prod_cnt);
          wr_data = 8'($urandom);
          wr_m[prod_cnt] = wr_data;
          prod_cnt++;
        end
      end else if (($urandom % 6) == 0) begin
        commit = 1'b1; cm = 1'b1; prod_cnt = 0;
      end
      sym_ready = r;

      // model: commit first, then the accepted symbol
      if (cm) begin
        for (int i = 0; i < PAY; i++) idle_m[i] = wr_m[i];
        m_pend = 1'b1;
      end
      if (sym_valid && r) begin
        model_symbol(ed, ek, tag);
        check(sym_data == ed && sym_k == ek, tag, int'({sym_k, sym_data}), int'({ek, ed}));
        if (ek && (ed == 8'h3C || ed == 8'hFB)) begin
          n_marks++;
          if (ed == 8'h3C) n_sync_marks++;
          if (!first_mark_seen) begin
            first_mark_seen = 1'b1;
            check(ed == 8'h3C, "R4 first marker is sync", int'(ed), 32'h3C);
          end
        end
      end
      prev_stall = sym_valid && !r;
      prev_d = sym_data;
      prev_k = sym_k;
      @(negedge clk);
    end
    wr_en = 1'b0; commit = 1'b0; sym_ready = 1'b0;

    // R3: one sync marker per RELOAD+1 markers, starting with the first
    check(n_marks > 2 * (RELOAD + 1), "R3 enough markers seen", n_marks, 2 * (RELOAD + 1));
    check(n_sync_marks == (n_marks + RELOAD) / (RELOAD + 1), "R3 sync marker cadence",
          n_sync_marks, (n_marks + RELOAD) / (RELOAD + 1));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule